// File: doc/BRIEF.md
# Flash Command Decoder and Validator

This block sits between a processor's command registers and the control logic of an on-chip flash array. Software places five 16-bit words on its inputs: a command word, three argument words, and the processor clock period in nanoseconds. A one-cycle start strobe makes the block check the command and every argument rule. It then either reports an error code or carries out the requested operation.

A valid programming command runs a timed program pulse followed by a verify request. A valid erase first asks the array whether the bank is already fully programmed and pre-programs it if it is not. It then applies a timed erase pulse and requests an erase verify. Pulse lengths are computed as cycle counts from nominal pulse widths (parameters) and the supplied clock period. A failed verify repeats the pulse up to a parameterised number of attempts. The array is outside the block: the block drives pulse enables and verify requests, and it reads a single verify-pass input.

Top module: `flash_cmd_check`

## Requirements
- R1: The command word decodes as follows, with `op` encoded 1=single word, 2=double word, 3=block, 4=erase, 5=status. Upper 12 bits 0x55A give single word, 0xDD4 give double word, and 0xAA5 give block, with `seg` taking the low nibble. 0xEEEE gives erase and 0x7777 gives status, both with `seg`=0. Any other word reports `err`=1.
- R2: An odd target offset reports `err`=2. For single and double word this is `arg1` bit 0. For block it is `arg1` bit 0 or `arg2` bit 0.
- R3: For block, let D = `arg2` − `arg1`. The command reports `err`=3 unless 0 ≤ D < 16384 and `arg3` + D < 16384.
- R4: Erase requires `arg1` = 0x5555, otherwise `err`=1. `arg2` and `arg3` must be equal and at most 3, otherwise `err`=4.
- R5: A zero `period_ns` on a program or erase command reports `err`=3. Error priority runs: opcode or erase key, then zero period, then odd offset, then range, then bank. A status command ignores the period.
- R6: For a rejected command, and for a status command, `done` pulses for one cycle in the cycle after start and `busy` stays low. `err` then holds the code (0 for status) until the next accepted start.
- R7: For a valid program command, `busy` rises in the cycle after start. `prog_pulse` stays high for ceil(PROG_NS/`period_ns`) cycles. Next comes one `verify_req` cycle with `verify_erased`=0. A pass there gives `done` with `err`=0 in the following cycle.
- R8: For a valid erase, the first cycle is a `verify_req` cycle with `verify_erased`=0. If that check fails, a pre-program pulse of ceil(PROG_NS/`period_ns`) cycles follows. Then `erase_pulse` runs for ceil(ERASE_NS/`period_ns`) cycles, followed by a `verify_req` cycle with `verify_erased`=1.
- R9: A failed verify repeats the pulse. After MAX_TRY failed attempts the block ends with `done` and `err`=5.
- R10: `busy` is high exactly from the accepted start to the cycle in which `done` rises. While it is high, `start` is ignored, and `op` and `seg` keep their values.
- R11: After reset, `busy`, `done`, `err`, `op`, `prog_pulse`, `erase_pulse` and `verify_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe |
| cmd | input | 16 | Command word |
| arg1 | input | 16 | Argument word 1 |
| arg2 | input | 16 | Argument word 2 |
| arg3 | input | 16 | Argument word 3 |
| period_ns | input | 16 | Clock period in ns |
| verify_ok | input | 1 | Array verify pass |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Result code |
| op | output | 3 | Decoded operation |
| seg | output | 4 | Decoded segment |
| prog_pulse | output | 1 | Program pulse enable |
| erase_pulse | output | 1 | Erase pulse enable |
| verify_req | output | 1 | Verify request |
| verify_erased | output | 1 | Verify type: 1 = erased, 0 = programmed |

## Verification
The bench builds the block with PROG_NS=100, ERASE_NS=300 and MAX_TRY=2. At these values pulse lengths stay a few cycles long. Rounding can therefore be observed both with an exact division (period 30 gives 10 erase cycles) and with a rounded-up one (period 40 gives 3 and 8). Retry exhaustion is reached after only two failed verifies. A block program spanning nearly a full page still finishes quickly.

// File: rtl/flash_cmd_check.sv
module flash_cmd_check #(
  parameter int PROG_NS  = 10000,
  parameter int ERASE_NS = 100000,
  parameter int MAX_TRY  = 4,
  parameter int CW       = 24,
  parameter int PAGE     = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] cmd,
  input  logic [15:0] arg1,
  input  logic [15:0] arg2,
  input  logic [15:0] arg3,
  input  logic [15:0] period_ns,
  input  logic        verify_ok,
  output logic        busy,
  output logic        done,
  output logic [2:0]  err,
  output logic [2:0]  op,
  output logic [3:0]  seg,
  output logic        prog_pulse,
  output logic        erase_pulse,
  output logic        verify_req,
  output logic        verify_erased
);
  localparam int TW = $clog2(MAX_TRY + 1);
  localparam logic [CW-1:0] ONE = 1;
  localparam logic [TW-1:0] TONE = 1;
  localparam logic [TW-1:0] TMAX = TW'(MAX_TRY);
  localparam logic [2:0] OP_NONE = 3'd0, OP_SGL = 3'd1, OP_DBL = 3'd2,
                         OP_BLK = 3'd3, OP_ERS = 3'd4, OP_STS = 3'd5;
  localparam logic [2:0] E_OK = 3'd0, E_OP = 3'd1, E_ODD = 3'd2,
                         E_RNG = 3'd3, E_BANK = 3'd4, E_VFY = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_VER, S_CHK, S_PRE, S_ERS, S_EVER} st_t;
  st_t st;

  logic [2:0]  dop, code;
  logic [3:0]  dseg;
  logic [16:0] span;
  logic [17:0] src_end;
  logic        span_bad, src_bad;
  logic [CW-1:0] per, pcyc_n, ecyc_n, pcyc, ecyc, cnt;
  logic [TW-1:0] tries;

  always_comb begin
    dop = OP_NONE;
    dseg = 4'd0;
    if (cmd[15:4] == 12'h55A)      begin dop = OP_SGL; dseg = cmd[3:0]; end
    else if (cmd[15:4] == 12'hDD4) begin dop = OP_DBL; dseg = cmd[3:0]; end
    else if (cmd[15:4] == 12'hAA5) begin dop = OP_BLK; dseg = cmd[3:0]; end
    else if (cmd == 16'hEEEE)      dop = OP_ERS;
    else if (cmd == 16'h7777)      dop = OP_STS;
  end

  assign span     = {1'b0, arg2} - {1'b0, arg1};
  assign span_bad = span[16] || (span >= 17'(PAGE));
  assign src_end  = {2'b0, arg3} + {1'b0, span};
  assign src_bad  = src_end >= 18'(PAGE);

  always_comb begin
    code = E_OK;
    case (dop)
      OP_NONE: code = E_OP;
      OP_SGL, OP_DBL:
        if (period_ns == 16'd0) code = E_RNG;
        else if (arg1[0])       code = E_ODD;
      OP_BLK:
        if (period_ns == 16'd0)         code = E_RNG;
        else if (arg1[0] || arg2[0])    code = E_ODD;
        else if (span_bad || src_bad)   code = E_RNG;
      OP_ERS:
        if (arg1 != 16'h5555)                   code = E_OP;
        else if (period_ns == 16'd0)            code = E_RNG;
        else if (arg2 != arg3 || arg2 > 16'd3)  code = E_BANK;
      default: code = E_OK;
    endcase
  end

  assign per    = (period_ns == 16'd0) ? ONE : CW'(period_ns);
  assign pcyc_n = (CW'(PROG_NS) + per - ONE) / per;
  assign ecyc_n = (CW'(ERASE_NS) + per - ONE) / per;

  assign prog_pulse    = (st == S_PROG) || (st == S_PRE);
  assign erase_pulse   = (st == S_ERS);
  assign verify_req    = (st == S_VER) || (st == S_CHK) || (st == S_EVER);
  assign verify_erased = (st == S_EVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; done <= 1'b0; err <= E_OK;
      op <= OP_NONE; seg <= 4'd0; cnt <= '0; pcyc <= ONE; ecyc <= ONE; tries <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            op <= dop; seg <= dseg; err <= code; tries <= TONE;
            pcyc <= pcyc_n; ecyc <= ecyc_n;
            if (code != E_OK || dop == OP_STS) done <= 1'b1;
            else begin
              busy <= 1'b1;
              if (dop == OP_ERS) st <= S_CHK;
              else begin st <= S_PROG; cnt <= pcyc_n - ONE; end
            end
          end
        S_PROG:
          if (cnt == '0) st <= S_VER; else cnt <= cnt - ONE;
        S_VER:
          if (verify_ok) begin st <= S_IDLE; busy <= 1'b0; done <= 1'b1; end
          else if (tries == TMAX) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1; err <= E_VFY;
          end else begin
            tries <= tries + TONE; st <= S_PROG; cnt <= pcyc - ONE;
          end
        S_CHK:
          if (verify_ok) begin st <= S_ERS; cnt <= ecyc - ONE; end
          else begin st <= S_PRE; cnt <= pcyc - ONE; end
        S_PRE:
          if (cnt == '0) begin st <= S_ERS; cnt <= ecyc - ONE; end
          else cnt <= cnt - ONE;
        S_ERS:
          if (cnt == '0) st <= S_EVER; else cnt <= cnt - ONE;
        S_EVER:
          if (verify_ok) begin st <= S_IDLE; busy <= 1'b0; done <= 1'b1; end
          else if (tries == TMAX) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1; err <= E_VFY;
          end else begin
            tries <= tries + TONE; st <= S_ERS; cnt <= ecyc - ONE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_act_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pulse || erase_pulse || verify_req) |-> busy);
  p_err_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err != E_OK) |-> !busy);
  p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_erase_then_verify_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_pulse) |-> (verify_req && verify_erased));
  p_prog_then_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> ((verify_req && !verify_erased) || erase_pulse));
  p_op_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> $stable(op));
endmodule

// File: tb/sim_flash_cmd_check.sv
module sim_flash_cmd_check;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verify_ok = 1'b1;
  logic [15:0] cmd = '0, arg1 = '0, arg2 = '0, arg3 = '0, period_ns = 16'd40;
  logic busy, done, prog_pulse, erase_pulse, verify_req, verify_erased;
  logic [2:0] err, op;
  logic [3:0] seg;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_check #(.PROG_NS(100), .ERASE_NS(300), .MAX_TRY(2)) u0 (
    .clk, .rst_n, .start, .cmd, .arg1, .arg2, .arg3, .period_ns, .verify_ok,
    .busy, .done, .err, .op, .seg, .prog_pulse, .erase_pulse, .verify_req, .verify_erased);

  // cmd, arg1, arg2, arg3, period, err, op, seg
  localparam int NV = 18;
  localparam logic [89:0] VEC [NV] = '{
    {16'h55A3, 16'h0100, 16'h1234, 16'h0000, 16'd40, 3'd0, 3'd1, 4'h3},
    {16'hDD47, 16'h0200, 16'h1111, 16'h2222, 16'd40, 3'd0, 3'd2, 4'h7},
    {16'hAA52, 16'h1000, 16'h1010, 16'h0000, 16'd40, 3'd0, 3'd3, 4'h2},
    {16'hEEEE, 16'h5555, 16'h0002, 16'h0002, 16'd40, 3'd0, 3'd4, 4'h0},
    {16'h7777, 16'h0000, 16'h0000, 16'h0000, 16'd0,  3'd0, 3'd5, 4'h0},
    {16'h1234, 16'h0000, 16'h0000, 16'h0000, 16'd40, 3'd1, 3'd0, 4'h0},
    {16'h55A0, 16'h0101, 16'h0000, 16'h0000, 16'd40, 3'd2, 3'd1, 4'h0},
    {16'hAA50, 16'h0000, 16'h0003, 16'h0000, 16'd40, 3'd2, 3'd3, 4'h0},
    {16'hAA50, 16'h0100, 16'h0080, 16'h0000, 16'd40, 3'd3, 3'd3, 4'h0},
    {16'hAA50, 16'h0000, 16'h4000, 16'h0000, 16'd40, 3'd3, 3'd3, 4'h0},
    {16'hAA50, 16'h0000, 16'h3FFE, 16'h0000, 16'd40, 3'd0, 3'd3, 4'h0},
    {16'hAA50, 16'h0000, 16'h0010, 16'h3FF0, 16'd40, 3'd3, 3'd3, 4'h0},
    {16'hEEEE, 16'h5555, 16'h0001, 16'h0002, 16'd40, 3'd4, 3'd4, 4'h0},
    {16'hEEEE, 16'h5555, 16'h0005, 16'h0005, 16'd40, 3'd4, 3'd4, 4'h0},
    {16'hEEEE, 16'h1234, 16'h0000, 16'h0000, 16'd40, 3'd1, 3'd4, 4'h0},
    {16'h55A1, 16'h0100, 16'h0000, 16'h0000, 16'd0,  3'd3, 3'd1, 4'h1},
    {16'h55A1, 16'h0101, 16'h0000, 16'h0000, 16'd0,  3'd3, 3'd1, 4'h1},
    {16'hDD40, 16'h0003, 16'h0000, 16'h0000, 16'd40, 3'd2, 3'd2, 4'h0}
  };

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [15:0] c, a1, a2, a3, p);
    cmd = c; arg1 = a1; arg2 = a2; arg3 = a3; period_ns = p; start = 1'b1;
    tick;
    start = 1'b0;
  endtask

  function automatic int count_prog();
    return 0;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 200) begin tick; n++; end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(!busy && !done && err == 0 && op == 0, "R11", {busy, done, err, op}, 0);
    chk(!prog_pulse && !erase_pulse && !verify_req, "R11",
        {prog_pulse, erase_pulse, verify_req}, 0);
    rst_n = 1'b1;
    tick;

    for (int i = 0; i < NV; i++) begin
      logic [89:0] v;
      string tg;
      v = VEC[i];
      verify_ok = 1'b1;
      case (v[9:7])
        3'd0: tg = "R1";
        3'd1: tg = "R1/R4";
        3'd2: tg = "R2";
        3'd3: tg = "R3/R5";
        default: tg = "R4";
      endcase
      kick(v[89:74], v[73:58], v[57:42], v[41:26], v[25:10]);
      if (v[9:7] != 3'd0 || v[6:4] == 3'd5) begin
        // R6 immediate result
        chk(done && !busy, "R6", {done, busy}, 2);
        chk(err == v[9:7], tg, err, v[9:7]);
        if (v[6:4] == 3'd5) chk(op == 3'd5, "R1", op, 5);
        tick;
        chk(!done && err == v[9:7], "R6", {done, err}, v[9:7]);
      end else begin
        chk(busy && !done, "R10", {busy, done}, 2);
        chk(op == v[6:4] && seg == v[3:0], tg, {op, seg}, {v[6:4], v[3:0]});
        wait_done(n);
        chk(done && err == 0 && !busy, "R7", {done, err, busy}, 4);
      end
      tick;
    end

    // R7 program pulse length, period 30 -> ceil(100/30)=4
    verify_ok = 1'b1;
    kick(16'h55A2, 16'h0010, 16'h0000, 16'h0000, 16'd30);
    n = 0;
    while (prog_pulse && n < 50) begin n++; tick; end
    chk(n == 4, "R7", n, 4);
    chk(verify_req && !verify_erased, "R7", {verify_req, verify_erased}, 2);
    tick;
    chk(done && err == 0, "R7", {done, err}, 4);
    tick;

    // R8 erase with failed pre-check, period 40: pre 3, erase 8
    kick(16'hEEEE, 16'h5555, 16'h0003, 16'h0003, 16'd40);
    chk(verify_req && !verify_erased && busy, "R8", {verify_req, verify_erased, busy}, 5);
    verify_ok = 1'b0;
    tick;
    verify_ok = 1'b1;
    n = 0;
    while (prog_pulse && n < 50) begin n++; tick; end
    chk(n == 3, "R8", n, 3);
    n = 0;
    while (erase_pulse && n < 50) begin n++; tick; end
    chk(n == 8, "R8", n, 8);
    chk(verify_req && verify_erased, "R8", {verify_req, verify_erased}, 3);
    tick;
    chk(done && err == 0, "R8", {done, err}, 4);
    tick;

    // R8 erase pulse with exact division, period 30 -> 10, pre-check passes
    kick(16'hEEEE, 16'h5555, 16'h0000, 16'h0000, 16'd30);
    tick;
    chk(erase_pulse && !prog_pulse, "R8", {erase_pulse, prog_pulse}, 2);
    n = 0;
    while (erase_pulse && n < 50) begin n++; tick; end
    chk(n == 10, "R8", n, 10);
    wait_done(n);
    tick;

    // R9 retry exhaustion on program, and R10 start ignored while busy
    verify_ok = 1'b0;
    kick(16'h55A4, 16'h0020, 16'h0000, 16'h0000, 16'd40);
    tick;
    cmd = 16'h7777; start = 1'b1;
    tick;
    start = 1'b0;
    chk(busy && op == 3'd1 && seg == 4'h4, "R10", {busy, op, seg}, {1'b1, 3'd1, 4'h4});
    n = 0;
    while (!verify_req && n < 50) begin tick; n++; end
    tick;
    chk(prog_pulse && busy, "R9", {prog_pulse, busy}, 3);
    wait_done(n);
    chk(done && err == 3'd5 && !busy, "R9", {done, err, busy}, {1'b1, 3'd5, 1'b0});
    tick;
    chk(!done && err == 3'd5, "R6", {done, err}, 5);

    // R5 priority: erase key beats zero period
    verify_ok = 1'b1;
    kick(16'hEEEE, 16'h0000, 16'h0000, 16'h0000, 16'd0);
    chk(done && err == 3'd1, "R5", err, 1);
    tick;

    summary();
  end
endmodule